// File: doc/BRIEF.md
# Serial Mode-3 Frame Master

This block is a synchronous serial master with an idle-high clock that changes data on falling clock edges and samples on rising clock edges. Words to be sent enter a transmit queue through a valid/ready push port. The engine sends each word most-significant bit first on `sdo` and captures the same number of bits from `sdi`. Each received word goes into a receive queue that the host drains through a valid/ready pop port. A low-active select line `sel_n` frames the transfer. While more words are queued, the engine sends them back to back without raising the select line.

Word length (4 to 16 bits) and the clock divider are sampled when a frame starts and hold for the whole frame. Each half of a serial clock period lasts `half_div + 1` system clocks.

Back-pressure rules:
- The push side moves a word only in a cycle where `tx_valid` and `tx_ready` are both high. `tx_data` must stay stable while `tx_valid` is high and `tx_ready` is low.
- The pop side presents the oldest word whenever `rx_valid` is high and holds it until `rx_ready` is seen high.
- The serial side cannot be stalled. A received word that finds the receive queue full, with no pop in that cycle, is discarded and sets a sticky overrun flag.

Top module: `spi3_frame_master`

## Requirements
- R1: Out of reset and whenever no frame is active, `sck` is 1, `sel_n` is 1, `sdo` is 0 and `sdo_oe` is 0.
- R2: A frame begins only while `enable` is 1 and the transmit queue is non-empty. In the cycle `sel_n` drops, `sdo_oe` rises, and it stays 1 until `sel_n` returns high.
- R3: The first falling edge of `sck` comes `half_div+1` system clocks after `sel_n` falls, and `sck` stays high in between. `sdo` stays 0 until that edge. Every later half period also lasts `half_div+1` clocks.
- R4: `sdo` changes only on falling `sck` edges and is steady at each rising edge. Bits go out most-significant first, and `sdi` is sampled at rising edges.
- R5: The effective word length is `word_len` clamped to 4..16, so a value below 4 acts as 4 and a value above 16 acts as 16. Changing `word_len` or `half_div` during a frame does not affect that frame.
- R6: A frame carrying k words of n bits keeps `sel_n` low for exactly (2·k·n + 2)·(half_div+1) system clocks. This means `sel_n` rises one full serial period after the last rising edge.
- R7: Each received word is queued right-aligned, with its upper bits zero, in the cycle its last bit is sampled. It is popped in arrival order through `rx_valid`/`rx_ready`.
- R8: A received word that finds the receive queue full (8 words) with no pop in that cycle is discarded and sets `overrun`, which stays 1 until reset. If a pop happens in the same cycle, the word is kept.
- R9: The transmit queue holds at most 8 words. `tx_ready` is 0 while it is full and the engine takes no word that cycle, and a word offered then is not accepted.
- R10: `busy` is 1 exactly while `sel_n` is 0.
- R11: Clearing `enable` during a frame does not cut the current word. The frame ends after that word, and the words still queued wait for `enable`.
- R12: `sck_oe` is 1 at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Permits new frames and word chaining |
| word_len | input | 5 | Requested bits per word (clamped to 4..16) |
| half_div | input | 8 | Half serial period minus one, in system clocks |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | 16 | Transmit word, right-aligned |
| tx_ready | output | 1 | Transmit queue can take a word |
| rx_valid | output | 1 | Received word available |
| rx_data | output | 16 | Oldest received word, right-aligned |
| rx_ready | input | 1 | Host takes the received word |
| sdi | input | 1 | Serial data in |
| sck | output | 1 | Serial clock, idle high |
| sck_oe | output | 1 | Serial clock pad enable |
| sel_n | output | 1 | Frame select, active low |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data pad enable |
| busy | output | 1 | Frame in progress |
| overrun | output | 1 | Sticky receive-drop flag |

## Verification
The collision of interest is a received word being written into a full receive queue in the same cycle the host pops that queue. The bench fills the receive queue with one eight-word frame and then starts a one-word frame. It counts from the falling select edge to the exact cycle of the last rising serial edge and raises `rx_ready` for only that cycle. The run passes if `overrun` stays clear and the drained order ends with the new word. A second pass withholds the pop and expects the word to be discarded and the flag to be set. A similar overlap on the transmit side, a host push while the engine takes a word from a full queue, comes up during the chained-frame sweeps.

// File: rtl/spi3m_pkg.sv
package spi3m_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } spi3m_state_e;
endpackage

// File: rtl/spi3m_fifo.sv
module spi3m_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] DEPTH_V = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_V  = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop, full;

  assign full      = (count == DEPTH_V);
  assign out_valid = (count != '0);
  assign do_pop    = out_ready && out_valid;
  assign in_ready  = !full || do_pop;
  assign do_push   = in_valid && in_ready;
  assign out_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_V) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST_V) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9 / R8: occupancy never passes the configured depth
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_V);

  // R7: a lone pop removes exactly one entry
  p_pop_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !do_push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/spi3m_tick.sv
module spi3m_tick #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] limit,
  output logic            tick
);
  logic [DIVW-1:0] cnt;

  assign tick = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R3: the half-period counter never runs past its limit
  p_half_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= limit));
endmodule

// File: rtl/spi3m_engine.sv
module spi3m_engine
  import spi3m_pkg::*;
#(
  parameter int DW   = 16,
  parameter int MINB = 4,
  parameter int DIVW = 8,
  parameter int LW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [LW-1:0]   word_len,
  input  logic [DIVW-1:0] half_div,
  input  logic            tx_avail,
  input  logic [DW-1:0]   tx_word,
  output logic            tx_take,
  output logic            rx_push,
  output logic [DW-1:0]   rx_word,
  input  logic            rx_room,
  input  logic            sdi,
  output logic            sck,
  output logic            sel_n,
  output logic            sdo,
  output logic            sdo_oe,
  output logic            busy,
  output logic            overrun
);
  localparam logic [LW-1:0] MINB_V = LW'(MINB);
  localparam logic [LW-1:0] DW_V   = LW'(DW);

  spi3m_state_e    st;
  logic            sck_q, sel_q, sdo_q, oe_q, ovr_q;
  logic [DW-1:0]   tx_sh, rx_sh, aligned;
  logic [LW-1:0]   bitn, bit_next, nbits_q, nb_in, nb_sel;
  logic [DIVW-1:0] div_q;
  logic            tick, start, chain, word_end;

  always_comb begin
    if (word_len < MINB_V)     nb_in = MINB_V;
    else if (word_len > DW_V)  nb_in = DW_V;
    else                       nb_in = word_len;
  end

  assign nb_sel   = (st == ST_IDLE) ? nb_in : nbits_q;
  assign aligned  = tx_word << (DW_V - nb_sel);
  assign bit_next = bitn + 1'b1;
  assign start    = (st == ST_IDLE) && enable && tx_avail;
  assign word_end = (st == ST_SHIFT) && tick && sck_q && (bitn == nbits_q);
  assign chain    = word_end && enable && tx_avail;
  assign tx_take  = start || chain;
  assign rx_push  = (st == ST_SHIFT) && tick && !sck_q && (bit_next == nbits_q);
  assign rx_word  = {rx_sh[DW-2:0], sdi};

  spi3m_tick #(.DIVW(DIVW)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (st != ST_IDLE),
    .limit (div_q),
    .tick  (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      sck_q   <= 1'b1;
      sel_q   <= 1'b1;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
      ovr_q   <= 1'b0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      bitn    <= '0;
      nbits_q <= MINB_V;
      div_q   <= '0;
    end else begin
      if (rx_push && !rx_room) ovr_q <= 1'b1;
      case (st)
        ST_IDLE: begin
          if (start) begin
            st      <= ST_LEAD;
            sel_q   <= 1'b0;
            oe_q    <= 1'b1;
            tx_sh   <= aligned;
            rx_sh   <= '0;
            bitn    <= '0;
            nbits_q <= nb_in;
            div_q   <= half_div;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            st    <= ST_SHIFT;
            sck_q <= 1'b0;
            sdo_q <= tx_sh[DW-1];
            tx_sh <= tx_sh << 1;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sck_q) begin
              sck_q <= 1'b1;
              rx_sh <= rx_word;
              bitn  <= bit_next;
            end else if (bitn != nbits_q) begin
              sck_q <= 1'b0;
              sdo_q <= tx_sh[DW-1];
              tx_sh <= tx_sh << 1;
            end else if (chain) begin
              sck_q <= 1'b0;
              sdo_q <= aligned[DW-1];
              tx_sh <= aligned << 1;
              rx_sh <= '0;
              bitn  <= '0;
            end else begin
              st <= ST_TAIL;
            end
          end
        end
        default: begin
          if (tick) begin
            st    <= ST_IDLE;
            sel_q <= 1'b1;
            oe_q  <= 1'b0;
            sdo_q <= 1'b0;
          end
        end
      endcase
    end
  end

  assign sck     = sck_q;
  assign sel_n   = sel_q;
  assign sdo     = sdo_q;
  assign sdo_oe  = oe_q;
  assign busy    = (st != ST_IDLE);
  assign overrun = ovr_q;

  p_idle_levels_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck && sel_n && !sdo && !sdo_oe));

  p_pad_on_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n |-> sdo_oe);

  p_lead_clock_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_n) |-> sck);

  p_sdo_still_at_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(sdo));

  p_len_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(nbits_q));

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_busy_tracks_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !sel_n);
endmodule

// File: rtl/spi3_frame_master.sv
module spi3_frame_master #(
  parameter int DATA_W     = 16,
  parameter int MIN_BITS   = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 8,
  localparam int LEN_W     = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [LEN_W-1:0]  word_len,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_ready,
  input  logic              sdi,
  output logic              sck,
  output logic              sck_oe,
  output logic              sel_n,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              busy,
  output logic              overrun
);
  logic              q_avail, q_take, r_push, r_room;
  logic [DATA_W-1:0] q_word, r_word;

  spi3m_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (tx_valid),
    .in_data   (tx_data),
    .in_ready  (tx_ready),
    .out_valid (q_avail),
    .out_data  (q_word),
    .out_ready (q_take)
  );

  spi3m_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (r_push),
    .in_data   (r_word),
    .in_ready  (r_room),
    .out_valid (rx_valid),
    .out_data  (rx_data),
    .out_ready (rx_ready)
  );

  spi3m_engine #(.DW(DATA_W), .MINB(MIN_BITS), .DIVW(DIV_W), .LW(LEN_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .word_len (word_len),
    .half_div (half_div),
    .tx_avail (q_avail),
    .tx_word  (q_word),
    .tx_take  (q_take),
    .rx_push  (r_push),
    .rx_word  (r_word),
    .rx_room  (r_room),
    .sdi      (sdi),
    .sck      (sck),
    .sel_n    (sel_n),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .busy     (busy),
    .overrun  (overrun)
  );

  // R12: master always drives its clock pad
  assign sck_oe = 1'b1;
endmodule

// File: tb/spi3_frame_master_bench.sv
module spi3_frame_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [4:0]  word_len = 5'd8;
  logic [7:0]  half_div = 8'd0;
  logic        tx_valid = 1'b0;
  logic [15:0] tx_data = 16'd0;
  logic        tx_ready, rx_valid, rx_ready = 1'b0;
  logic [15:0] rx_data;
  logic        sdi, sck, sck_oe, sel_n, sdo, sdo_oe, busy, overrun;

  always #2.5 clk = ~clk;
  assign sdi = ~sdo;

  spi3_frame_master u_spi3_frame_master (
    .clk(clk), .rst_n(rst_n), .enable(enable), .word_len(word_len),
    .half_div(half_div), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .sdi(sdi), .sck(sck), .sck_oe(sck_oe),
    .sel_n(sel_n), .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy), .overrun(overrun)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int exp_w [0:15];

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL all watchdog: actual=expired expected=finished");
    report();
  end

  // line monitor, sampled mid-cycle
  int low_cnt = 0, lead_cnt = 0, rise_cnt = 0, bitc = 0, capn = 0;
  int lead_bad = 0, oe_bad = 0, busy_bad = 0, idle_bad = 0, shreg = 0;
  int mon_n = 4;
  int cap [0:15];
  bit lead_done = 1'b0, prev_sel = 1'b1, prev_sck = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy != !sel_n) busy_bad++;
      if (sel_n && (!sck || sdo || sdo_oe || !sck_oe)) idle_bad++;
      if (!sel_n && prev_sel) begin
        low_cnt = 1; lead_cnt = 1; lead_done = 1'b0; rise_cnt = 0;
        bitc = 0; capn = 0; shreg = 0; lead_bad = 0; oe_bad = 0;
        if (sdo) lead_bad++;
        if (!sdo_oe) oe_bad++;
      end else if (!sel_n) begin
        low_cnt++;
        if (!sdo_oe) oe_bad++;
        if (!lead_done) begin
          if (!sck) lead_done = 1'b1;
          else begin
            lead_cnt++;
            if (sdo) lead_bad++;
          end
        end
        if (sck && !prev_sck) begin
          shreg = (shreg << 1) | int'(sdo);
          bitc++;
          rise_cnt++;
          if (bitc == mon_n) begin
            if (capn < 16) cap[capn] = shreg;
            capn++;
            shreg = 0;
            bitc = 0;
          end
        end
      end
      prev_sel = sel_n;
      prev_sck = sck;
    end
  end

  task automatic push_tx(input int w);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data = 16'(w);
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    #1 tx_valid = 1'b0;
  endtask

  task automatic pop_rx(input string req, input int exp);
    @(negedge clk);
    chk(req, "rx_valid before pop", int'(rx_valid), 1);
    chk(req, "rx word", int'(rx_data), exp);
    rx_ready = 1'b1;
    @(posedge clk);
    #1 rx_ready = 1'b0;
  endtask

  task automatic go_frame();
    @(negedge clk);
    enable = 1'b1;
    while (sel_n) @(negedge clk);
    while (!sel_n) @(negedge clk);
    enable = 1'b0;
  endtask

  task automatic check_lines(input int n, input int dv, input int kf);
    chk("R6", "select low cycles", low_cnt, (2 * kf * n + 2) * (dv + 1));
    chk("R3", "lead-in cycles", lead_cnt, dv + 1);
    chk("R3", "sdo low in lead-in", lead_bad, 0);
    chk("R2", "sdo_oe held in frame", oe_bad, 0);
    chk("R4", "rising edge count", rise_cnt, kf * n);
    chk("R5", "words in frame", capn, kf);
    for (int j = 0; j < kf && j < 16; j++) chk("R4", "sent word msb-first", cap[j], exp_w[j]);
  endtask

  task automatic check_frame(input int n, input int dv, input int kf);
    check_lines(n, dv, kf);
    for (int j = 0; j < kf; j++) pop_rx("R7", (~exp_w[j]) & ((1 << n) - 1));
  endtask

  task automatic run_frame(input int ws, input int n, input int dv, input int k, input bit mid);
    @(negedge clk);
    enable = 1'b0;
    word_len = 5'(ws);
    half_div = 8'(dv);
    mon_n = n;
    for (int j = 0; j < k; j++) begin
      exp_w[j] = ((n * 53 + j * 97 + dv * 29 + 5) ^ ((j == 0) ? 'h5555 : 0)) & ((1 << n) - 1);
      push_tx(exp_w[j]);
    end
    repeat (3) @(negedge clk);
    chk("R2", "no frame while disabled", int'(sel_n), 1);
    enable = 1'b1;
    while (sel_n) @(negedge clk);
    if (mid) begin
      word_len = (n == 16) ? 5'd4 : 5'd16;
      half_div = 8'((dv + 1) % 3);
    end
    while (!sel_n) @(negedge clk);
    enable = 1'b0;
    check_frame(n, dv, k);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R1", "reset sck", int'(sck), 1);
    chk("R1", "reset sel_n", int'(sel_n), 1);
    chk("R1", "reset sdo", int'(sdo), 0);
    chk("R1", "reset sdo_oe", int'(sdo_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "sck_oe", int'(sck_oe), 1);
    chk("R10", "busy idle", int'(busy), 0);
    chk("R9", "tx_ready empty", int'(tx_ready), 1);

    // R2: enabled but nothing queued
    enable = 1'b1;
    repeat (20) @(negedge clk);
    chk("R2", "no frame on empty queue", int'(sel_n), 1);
    enable = 1'b0;

    // sweep word length and divider; 1..3 chained words
    for (int n = 4; n <= 16; n++)
      for (int dv = 0; dv <= 2; dv++)
        run_frame(n, n, dv, 1 + (n % 3), 1'b0);

    // R5 clamps and frozen settings
    run_frame(2, 4, 1, 2, 1'b0);
    run_frame(31, 16, 0, 1, 1'b0);
    run_frame(8, 8, 1, 2, 1'b1);
    run_frame(4, 4, 2, 3, 1'b1);

    // R11: disable during first word of a three-word queue
    @(negedge clk);
    word_len = 5'd6; half_div = 8'd1; mon_n = 6;
    for (int j = 0; j < 3; j++) begin
      exp_w[j] = (j * 21 + 11) & 63;
      push_tx(exp_w[j]);
    end
    @(negedge clk);
    enable = 1'b1;
    while (sel_n) @(negedge clk);
    enable = 1'b0;
    while (!sel_n) @(negedge clk);
    check_frame(6, 1, 1);
    repeat (10) @(negedge clk);
    chk("R11", "queued words wait", int'(sel_n), 1);
    exp_w[0] = exp_w[1];
    exp_w[1] = exp_w[2];
    go_frame();
    check_frame(6, 1, 2);

    // R9: full transmit queue, then R8 overlap of push and pop
    @(negedge clk);
    word_len = 5'd4; half_div = 8'd0; mon_n = 4;
    for (int j = 0; j < 8; j++) begin
      exp_w[j] = (j * 5 + 3) & 15;
      push_tx(exp_w[j]);
    end
    @(negedge clk);
    chk("R9", "tx_ready when full", int'(tx_ready), 0);
    tx_valid = 1'b1; tx_data = 16'h000f;
    repeat (3) @(negedge clk);
    tx_valid = 1'b0;
    go_frame();
    check_lines(4, 0, 8);
    chk("R9", "refused word absent", capn, 8);
    chk("R8", "no overrun at exactly full", int'(overrun), 0);
    exp_w[8] = 'ha;
    push_tx(exp_w[8]);
    @(negedge clk);
    enable = 1'b1;
    while (sel_n) @(negedge clk);
    repeat (7) @(posedge clk);
    @(negedge clk);
    rx_ready = 1'b1;
    @(posedge clk);
    #1 rx_ready = 1'b0;
    while (!sel_n) @(negedge clk);
    enable = 1'b0;
    chk("R8", "same-cycle pop keeps word", int'(overrun), 0);
    for (int j = 1; j <= 8; j++) pop_rx("R8", (~exp_w[j]) & 15);
    @(negedge clk);
    chk("R8", "queue drained", int'(rx_valid), 0);

    // R8: true overrun
    for (int j = 0; j < 8; j++) begin
      exp_w[j] = (j * 7 + 1) & 15;
      push_tx(exp_w[j]);
    end
    go_frame();
    push_tx(3);
    go_frame();
    chk("R8", "overrun set", int'(overrun), 1);
    for (int j = 0; j < 8; j++) pop_rx("R8", (~exp_w[j]) & 15);
    @(negedge clk);
    chk("R8", "dropped word absent", int'(rx_valid), 0);
    chk("R8", "overrun sticky", int'(overrun), 1);

    chk("R1", "idle level violations", idle_bad, 0);
    chk("R10", "busy mismatches", busy_bad, 0);
    report();
  end
endmodule